// File: doc/BRIEF.md
# Lane Sync Header and Multiblock Alignment Tracker

This block watches the 2-bit sync headers of one 64b/66b-coded lane and builds up lock in two stages. It first declares header lock once enough consecutive legal headers have arrived. It then finds the extended multiblock boundary by looking for marker bits carried in the header pilot stream. It declares extended multiblock lock once several whole extended multiblocks in a row have carried their markers at the expected positions. After that it tags outgoing payload words with start-of-multiblock and start-of-extended-multiblock flags.

Blocks come in on a valid/ready stream, one 66-bit block per accepted beat. The 64-bit payload leaves on a valid/ready stream only while extended multiblock lock holds. Before lock, every offered block is consumed for alignment and its payload is dropped, so `in_ready` stays high. Once locked, `in_ready` follows `out_ready`, so back-pressure from the sink stalls the lane with no loss and no advance of the alignment counters. A multiblock is 32 blocks long and an extended multiblock is `EMB_MBS` multiblocks long.

Top module: `lane_sync_align`

## Requirements
- R1: A header is legal when bits [65:64] of the block are 2'b01 or 2'b10. `sh_lock` rises in the cycle after the 64th consecutive legal header is accepted.
- R2: Before header lock, an illegal header (2'b00 or 2'b11) resets the consecutive count to zero, so 64 further legal headers are needed.
- R3: An illegal header accepted while `sh_lock` is high clears `sh_lock` and `emb_lock` together in the next cycle, and both counts restart.
- R4: The pilot bit of a block is header bit 65 (2'b10 gives 1, 2'b01 gives 0). Block positions within a multiblock are numbered 0 to 31. Position 31 carries pilot 1, positions 27 to 30 carry pilot 0, and position 4 carries pilot 1 only in the last multiblock of an extended multiblock. All other positions are ignored.
- R5: With `sh_lock` high, the first block at position 31 of a last multiblock, recognised from the marker history, fixes the boundary. `emb_lock` rises in the cycle after the fourth further consecutive extended multiblock with correct markers.
- R6: A wrong marker before `emb_lock` restarts the boundary search and the sequence count, and does not raise `align_err`.
- R7: A wrong marker while `emb_lock` is high raises `align_err` for exactly one cycle and clears `emb_lock` in the same cycle. `sh_lock` stays high.
- R8: While `out_valid` is high, `out_somb` marks the block at position 0 of a multiblock. `out_soemb` additionally marks position 0 of the first multiblock of an extended multiblock.
- R9: `out_valid` equals `in_valid` while `emb_lock` is high and is 0 otherwise. `out_data` is bits [63:0] of the block. `in_ready` is 1 without `emb_lock` and follows `out_ready` with it. A stalled block does not advance block positions.
- R10: After reset, `sh_lock`, `emb_lock`, `align_err` and `out_valid` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Input block taken this cycle when high with in_valid |
| in_block | input | 66 | Sync header in [65:64], payload in [63:0] |
| out_valid | output | 1 | Payload word valid |
| out_ready | input | 1 | Sink accepts payload word |
| out_data | output | 64 | Payload word |
| out_somb | output | 1 | Start of multiblock flag |
| out_soemb | output | 1 | Start of extended multiblock flag |
| sh_lock | output | 1 | Header lock |
| emb_lock | output | 1 | Extended multiblock lock |
| align_err | output | 1 | One-cycle pulse on a marker fault after lock |

## Verification
The stimulus first reaches lock with exactly 63 and then 64 legal headers, which catches an off-by-one in the header threshold. It also breaks the header run partway before lock. One case corrupts a position-4 marker mid-count, so the pilot history then holds a false boundary that must be rejected within one multiblock; a design that raised an error here, or that trusted the first hit, would lock late or on the wrong phase. A marker fault after lock must pulse the error and drop only the second-level lock. An illegal header must drop both levels together. Finally, a stalled output beat must not move the marker phase, which would shift the start flags off position 0.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  localparam int HDR_W = 2;

  typedef enum logic [0:0] {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } align_state_t;

  function automatic logic hdr_legal(input logic [HDR_W-1:0] hdr);
    return hdr[1] ^ hdr[0];
  endfunction

  function automatic logic hdr_pilot(input logic [HDR_W-1:0] hdr);
    return hdr[1];
  endfunction

endpackage

// File: rtl/sh_tracker.sv
module sh_tracker #(
  parameter int LOCK_HDRS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       hdr_ok,
  output logic       sh_lock
);
  localparam int CW = $clog2(LOCK_HDRS + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      sh_lock <= 1'b0;
    end else if (accept) begin
      if (!hdr_ok) begin
        run_cnt <= '0;
        sh_lock <= 1'b0;
      end else if (!sh_lock) begin
        if (run_cnt == CW'(LOCK_HDRS - 1)) begin
          sh_lock <= 1'b1;
          run_cnt <= '0;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  end

  // lock can only appear right after a legal accepted header
  p_rise_on_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_lock) |-> $past(accept && hdr_ok));

  // an illegal header always removes lock
  p_drop_on_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hdr_ok) |=> !sh_lock);

endmodule

// File: rtl/pilot_hist.sv
module pilot_hist #(
  parameter int DEPTH = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             clear,
  input  logic             pilot,
  output logic [DEPTH-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (accept) begin
      if (clear) hist <= '0;
      else       hist <= {hist[DEPTH-2:0], pilot};
    end
  end
endmodule

// File: rtl/mb_aligner.sv
module mb_aligner
  import lane_align_pkg::*;
#(
  parameter int MB_LEN     = 32,
  parameter int EMB_MBS    = 4,
  parameter int LOCK_SEQS  = 4,
  parameter int EOEMB_POS  = 4,
  parameter int EOMB_ZEROS = 4,
  parameter int HD         = MB_LEN - 1 - EOEMB_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          hdr_ok,
  input  logic          sh_lock,
  input  logic          pilot,
  input  logic [HD-1:0] hist,
  output logic          emb_lock,
  output logic          align_err,
  output logic          somb,
  output logic          soemb
);
  localparam int IW = $clog2(MB_LEN);
  localparam int EW = (EMB_MBS > 1) ? $clog2(EMB_MBS) : 1;
  localparam int SW = $clog2(LOCK_SEQS + 1);
  localparam int ZERO_FIRST = MB_LEN - 1 - EOMB_ZEROS;

  align_state_t  state;
  logic [IW-1:0] idx;
  logic [EW-1:0] mb;
  logic [SW-1:0] seq_cnt;

  logic last_mb, at_end, checked, expect_bit, mismatch, hunt_hit, active;

  always_comb begin
    last_mb    = (mb == EW'(EMB_MBS - 1));
    at_end     = (idx == IW'(MB_LEN - 1));
    checked    = 1'b0;
    expect_bit = 1'b0;
    if (at_end) begin
      checked    = 1'b1;
      expect_bit = 1'b1;
    end else if (idx >= IW'(ZERO_FIRST)) begin
      checked    = 1'b1;
      expect_bit = 1'b0;
    end else if (idx == IW'(EOEMB_POS)) begin
      checked    = 1'b1;
      expect_bit = last_mb;
    end
    mismatch = checked && (pilot != expect_bit);
    hunt_hit = pilot && (hist[EOMB_ZEROS-1:0] == '0) && hist[HD-1];
    active   = accept && hdr_ok && sh_lock;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      idx       <= '0;
      mb        <= '0;
      seq_cnt   <= '0;
      emb_lock  <= 1'b0;
      align_err <= 1'b0;
    end else begin
      align_err <= 1'b0;
      if (accept && !(hdr_ok && sh_lock)) begin
        state    <= ST_HUNT;
        seq_cnt  <= '0;
        emb_lock <= 1'b0;
      end else if (active) begin
        if (state == ST_HUNT) begin
          if (hunt_hit) begin
            state   <= ST_TRACK;
            idx     <= '0;
            mb      <= '0;
            seq_cnt <= '0;
          end
        end else if (mismatch) begin
          state     <= ST_HUNT;
          seq_cnt   <= '0;
          align_err <= emb_lock;
          emb_lock  <= 1'b0;
        end else begin
          if (at_end) begin
            idx <= '0;
            mb  <= last_mb ? '0 : mb + 1'b1;
            if (last_mb && !emb_lock) begin
              if (seq_cnt == SW'(LOCK_SEQS - 1)) begin
                emb_lock <= 1'b1;
                seq_cnt  <= '0;
              end else begin
                seq_cnt <= seq_cnt + 1'b1;
              end
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  assign somb  = emb_lock && (idx == '0);
  assign soemb = somb && (mb == '0);

  p_emb_needs_sh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    emb_lock |-> sh_lock);

  p_err_clears_emb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !emb_lock);

  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> !align_err);

  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(emb_lock) && $stable(somb) && $stable(soemb));

endmodule

// File: rtl/lane_sync_align.sv
module lane_sync_align
  import lane_align_pkg::*;
#(
  parameter int LOCK_HDRS  = 64,
  parameter int MB_LEN     = 32,
  parameter int EMB_MBS    = 4,
  parameter int LOCK_SEQS  = 4,
  parameter int EOEMB_POS  = 4,
  parameter int EOMB_ZEROS = 4,
  parameter int PAY_W      = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PAY_W+HDR_W-1:0] in_block,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PAY_W-1:0]       out_data,
  output logic                   out_somb,
  output logic                   out_soemb,
  output logic                   sh_lock,
  output logic                   emb_lock,
  output logic                   align_err
);
  localparam int HD = MB_LEN - 1 - EOEMB_POS;

  logic [HDR_W-1:0] hdr;
  logic             hdr_ok, pilot, accept, somb_i, soemb_i;
  logic [HD-1:0]    hist;

  assign hdr      = in_block[PAY_W +: HDR_W];
  assign hdr_ok   = hdr_legal(hdr);
  assign pilot    = hdr_pilot(hdr);
  assign in_ready = !emb_lock || out_ready;
  assign accept   = in_valid && in_ready;

  sh_tracker #(.LOCK_HDRS(LOCK_HDRS)) u_sh (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hdr_ok(hdr_ok), .sh_lock(sh_lock)
  );

  pilot_hist #(.DEPTH(HD)) u_hist (
    .clk(clk), .rst_n(rst_n), .accept(accept), .clear(!hdr_ok),
    .pilot(pilot), .hist(hist)
  );

  mb_aligner #(
    .MB_LEN(MB_LEN), .EMB_MBS(EMB_MBS), .LOCK_SEQS(LOCK_SEQS),
    .EOEMB_POS(EOEMB_POS), .EOMB_ZEROS(EOMB_ZEROS), .HD(HD)
  ) u_align (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hdr_ok(hdr_ok),
    .sh_lock(sh_lock), .pilot(pilot), .hist(hist),
    .emb_lock(emb_lock), .align_err(align_err), .somb(somb_i), .soemb(soemb_i)
  );

  assign out_valid = in_valid && emb_lock;
  assign out_data  = in_block[PAY_W-1:0];
  assign out_somb  = out_valid && somb_i;
  assign out_soemb = out_valid && soemb_i;

  p_flags_need_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_somb || out_soemb) |-> out_valid);

  p_soemb_in_somb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_soemb |-> out_somb);

endmodule

// File: tb/lane_sync_align_test.sv
module lane_sync_align_test;
  localparam int E = 2;
  localparam int EMB = 32 * E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [65:0] in_block = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_somb, out_soemb, sh_lock, emb_lock, align_err;

  int checks = 0;
  int errors = 0;
  int g = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_sync_align #(.EMB_MBS(E)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_somb(out_somb), .out_soemb(out_soemb),
    .sh_lock(sh_lock), .emb_lock(emb_lock), .align_err(align_err)
  );

  // row: count[15:0] kind[1:0] exp_sh exp_emb exp_err
  // kind 0 clean, 1 header 00 on last, 2 header 11 on last, 3 pilot flipped on last
  localparam int NROWS = 12;
  localparam logic [20:0] ROWS [NROWS] = '{
    {16'd63,  2'd0, 3'b000},
    {16'd1,   2'd0, 3'b100},
    {16'd320, 2'd0, 3'b110},
    {16'd32,  2'd0, 3'b110},
    {16'd32,  2'd3, 3'b101},
    {16'd320, 2'd0, 3'b110},
    {16'd1,   2'd1, 3'b000},
    {16'd30,  2'd2, 3'b000},
    {16'd63,  2'd0, 3'b000},
    {16'd1,   2'd0, 3'b100},
    {16'd166, 2'd3, 3'b100},
    {16'd315, 2'd0, 3'b110}
  };

  function automatic string row_tag(input int r);
    case (r)
      0, 1:  return "R1";
      2, 3:  return "R5";
      4:     return "R7";
      5:     return "R4";
      6:     return "R3";
      7, 8:  return "R2";
      9:     return "R1";
      10:    return "R6";
      default: return "R6";
    endcase
  endfunction

  function automatic logic ref_pilot(input int n);
    int pos, idx, m;
    pos = n % EMB;
    idx = pos % 32;
    m   = pos / 32;
    if (idx == 31) return 1'b1;
    if (idx >= 27) return 1'b0;
    if (idx == 4)  return (m == E - 1);
    return 1'b0;
  endfunction

  function automatic logic [65:0] make_block(input int n, input logic [1:0] kind);
    logic p;
    logic [1:0] h;
    p = ref_pilot(n) ^ (kind == 2'd3);
    h = p ? 2'b10 : 2'b01;
    if (kind == 2'd1) h = 2'b00;
    if (kind == 2'd2) h = 2'b11;
    return {h, n[31:0], ~n[31:0]};
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [1:0] kind);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_block = make_block(g, (i == n - 1) ? kind : 2'd0);
      @(posedge clk);
      g++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state, R9 ready without lock even with sink stalled
    check("R10", "sh_lock", 64'(sh_lock), 64'd0);
    check("R10", "emb_lock", 64'(emb_lock), 64'd0);
    check("R10", "align_err", 64'(align_err), 64'd0);
    check("R10", "out_valid", 64'(out_valid), 64'd0);
    check("R9", "in_ready unlocked", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    out_ready = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      send(int'(ROWS[r][20:5]), ROWS[r][4:3]);
      check(row_tag(r), $sformatf("row %0d sh_lock", r), 64'(sh_lock), 64'(ROWS[r][2]));
      check(row_tag(r), $sformatf("row %0d emb_lock", r), 64'(emb_lock), 64'(ROWS[r][1]));
      check(row_tag(r), $sformatf("row %0d align_err", r), 64'(align_err), 64'(ROWS[r][0]));
      if (r == 4) begin
        @(negedge clk);
        check("R7", "err one cycle", 64'(align_err), 64'd0);
      end
    end

    // R8 start flags at multiblock position 0 of the first multiblock
    @(negedge clk);
    in_valid = 1'b1;
    in_block = make_block(g, 2'd0);
    #1;
    check("R8", "somb at pos0", 64'(out_somb), 64'd1);
    check("R8", "soemb at pos0", 64'(out_soemb), 64'd1);
    check("R9", "out_valid locked", 64'(out_valid), 64'd1);
    check("R9", "out_data", out_data, {g[31:0], ~g[31:0]});
    @(posedge clk);
    g++;
    @(negedge clk);
    in_block = make_block(g, 2'd0);
    #1;
    check("R8", "somb at pos1", 64'(out_somb), 64'd0);
    // R9 back-pressure: stall one cycle
    out_ready = 1'b0;
    #1;
    check("R9", "in_ready stalled", 64'(in_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b0;
    send(31, 2'd0);
    @(negedge clk);
    in_valid = 1'b1;
    in_block = make_block(g, 2'd0);
    #1;
    check("R9", "stall kept phase somb", 64'(out_somb), 64'd1);
    check("R8", "second multiblock soemb", 64'(out_soemb), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule